// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block sits between a MAC-side byte stream and the transmit half of a media-independent interface. The byte stream uses a valid/ready handshake with a last-byte marker, and carries whole frames whose bytes, FCS included, are already final. The block generates the frame lead-in itself: fifteen nibbles of 0x5 and then one delimiter nibble of 0xD. It then sends every payload byte as two nibbles, low nibble first. All outputs are registered on the transmit clock that the PHY supplies, which runs at 2.5 MHz or 25 MHz depending on line rate.

The enable line rises with the first lead-in nibble and stays high until the high nibble of the last byte has been sent. While the enable line is low, the data bus is held at zero. After every frame the enable line stays low for a minimum gap before the next lead-in can begin.

If the stream runs dry in the middle of a frame, the frame is cut short at once and a one-clock underrun pulse is raised. The controller has six states:
- ST_IDLE: waiting for a frame.
- ST_PREAMBLE: the fifteen 0x5 nibbles.
- ST_SFD: the 0xD nibble.
- ST_LOW: the low nibble of a byte.
- ST_HIGH: the high nibble of a byte.
- ST_GAP: the inter-frame gap.

Its transitions are:
- start: ST_IDLE to ST_PREAMBLE, when a byte is offered.
- lead_done: ST_PREAMBLE to ST_SFD.
- take_first: ST_SFD to ST_LOW.
- split: ST_LOW to ST_HIGH.
- take_next: ST_HIGH to ST_LOW.
- frame_end: ST_HIGH to ST_GAP, after the last byte.
- underrun: ST_SFD or ST_HIGH to ST_GAP, when no byte is offered.
- gap_idle: ST_GAP to ST_IDLE.
- gap_restart: ST_GAP to ST_PREAMBLE, when a byte is waiting as the gap expires.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is held and on the first clock after it, tx_en, txd, s_ready and underrun are all 0.
- R2: A frame starts only when s_valid is high. tx_en rises on the same clock edge that puts the first lead-in nibble 0x5 on txd. Exactly 15 nibbles of 0x5 are followed by one nibble of 0xD.
- R3: Each accepted byte appears on txd as two consecutive nibbles: bits 3:0 first, then bits 7:4. txd[0] is the least significant bit, and bytes are sent in the order they were accepted.
- R4: tx_en stays high without a break from the first lead-in nibble through the high nibble of the byte marked s_last. It is low on the following clock.
- R5: Whenever tx_en is low, txd is 0.
- R6: s_ready is high exactly in those clocks whose next edge would put a byte's low nibble on txd. These are the clock showing the 0xD nibble, and the clock showing the high nibble of a byte not marked last. s_ready is 0 in every other clock. A byte is taken when s_valid and s_ready are both high.
- R7: If s_valid is low while s_ready is high, tx_en goes low on the next edge and underrun is high for exactly that one clock. No further byte of that frame is sent.
- R8: Between the end of one frame and the first lead-in nibble of the next, tx_en is low for at least 24 clocks. When the next frame is already offered as the gap begins, it is low for exactly 24 clocks.
- R9: With s_valid held low, tx_en stays low and txd stays 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock from the PHY; every output changes on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| s_data | input | 8 | Byte offered by the MAC-side stream |
| s_valid | input | 1 | s_data is valid |
| s_last | input | 1 | s_data is the last byte of its frame |
| s_ready | output | 1 | Byte on s_data is taken at this edge if s_valid is high |
| txd | output | 4 | Transmit nibble; bit 0 is the least significant bit |
| tx_en | output | 1 | Transmit enable, high for the whole frame |
| underrun | output | 1 | One-clock pulse when a frame is cut short for lack of data |

## Verification
A wrong lead-in count shows within the first 17 clocks of a frame as a misplaced 0xD nibble or as data arriving early. A stuck or skipped nibble phase shows at once as swapped or repeated nibbles, and as an s_ready pulse in the wrong clock. A mistimed gap counter shows on the next back-to-back frame as a low run other than 24 clocks. A wrong last-byte or underrun flag shows as tx_en falling one or more nibbles away from the expected clock. Every frame is therefore replayed from a per-clock log of the pins. It is compared against a lead-in, byte and gap layout worked out from the frame length and the underrun position.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } tx_state_e;

endpackage

// File: rtl/mii_tx_span_counter.sv
module mii_tx_span_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/mii_tx_byte_hold.sv
module mii_tx_byte_hold #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NIB_W-1:0] upper_in,
    input  logic             last_in,
    output logic [NIB_W-1:0] upper_q,
    output logic             last_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            last_q  <= 1'b0;
        end else if (load) begin
            upper_q <= upper_in;
            last_q  <= last_in;
        end
    end

endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NIB_W-1:0]   s_data,
    input  logic                 s_valid,
    input  logic                 s_last,
    output logic                 s_ready,
    output logic [NIB_W-1:0]     txd,
    output logic                 tx_en,
    output logic                 underrun
);

    localparam int BYTE_W  = 2 * NIB_W;
    localparam int SPAN    = (PRE_NIBBLES > IFG_NIBBLES) ? PRE_NIBBLES : IFG_NIBBLES;
    localparam int CNT_W   = $clog2(SPAN + 1);
    localparam logic [NIB_W-1:0] PRE_NIB = {(NIB_W/2){2'b01}};
    localparam logic [NIB_W-1:0] SFD_NIB = PRE_NIB | (NIB_W'(1) << (NIB_W - 1));
    localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_NIBBLES - 1);
    localparam logic [CNT_W-1:0] IFG_END = CNT_W'(IFG_NIBBLES - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] span_cnt;
    logic             cnt_clear, cnt_adv;
    logic [NIB_W-1:0] upper_q;
    logic             last_q;
    logic             take;
    logic [NIB_W-1:0] txd_d;
    logic             en_d, und_d;

    assign s_ready = (state_q == ST_SFD) || (state_q == ST_HIGH && !last_q);
    assign take    = s_ready && s_valid;

    mii_tx_span_counter #(.W(CNT_W)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_adv),
        .count   (span_cnt)
    );

    mii_tx_byte_hold #(.NIB_W(NIB_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .upper_in (s_data[BYTE_W-1:NIB_W]),
        .last_in  (s_last),
        .upper_q  (upper_q),
        .last_q   (last_q)
    );

    // Next-state and counter control
    always_comb begin
        state_d   = state_q;
        cnt_clear = 1'b0;
        cnt_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid) begin
                    state_d   = ST_PREAMBLE;
                    cnt_clear = 1'b1;
                end
            end
            ST_PREAMBLE: begin
                if (span_cnt == PRE_END) begin
                    state_d = ST_SFD;
                end else begin
                    cnt_adv = 1'b1;
                end
            end
            ST_SFD: begin
                if (take) begin
                    state_d = ST_LOW;
                end else begin
                    state_d   = ST_GAP;
                    cnt_clear = 1'b1;
                end
            end
            ST_LOW: begin
                state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (take) begin
                    state_d = ST_LOW;
                end else begin
                    state_d   = ST_GAP;
                    cnt_clear = 1'b1;
                end
            end
            ST_GAP: begin
                if (span_cnt == IFG_END) begin
                    cnt_clear = 1'b1;
                    state_d   = s_valid ? ST_PREAMBLE : ST_IDLE;
                end else begin
                    cnt_adv = 1'b1;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                cnt_clear = 1'b1;
            end
        endcase
    end

    // Output values for the next clock, decoded from the next state
    always_comb begin
        en_d  = 1'b0;
        txd_d = '0;
        und_d = 1'b0;
        unique case (state_d)
            ST_PREAMBLE: begin
                en_d  = 1'b1;
                txd_d = PRE_NIB;
            end
            ST_SFD: begin
                en_d  = 1'b1;
                txd_d = SFD_NIB;
            end
            ST_LOW: begin
                en_d  = 1'b1;
                txd_d = s_data[NIB_W-1:0];
            end
            ST_HIGH: begin
                en_d  = 1'b1;
                txd_d = upper_q;
            end
            ST_GAP: begin
                und_d = (state_q == ST_GAP) ? 1'b0 : s_ready;
            end
            default: begin
                en_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tx_en    <= 1'b0;
            txd      <= '0;
            underrun <= 1'b0;
        end else begin
            state_q  <= state_d;
            tx_en    <= en_d;
            txd      <= txd_d;
            underrun <= und_d;
        end
    end

    // Low-run tracker used only by the gap assertion
    logic [CNT_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= CNT_W'(IFG_NIBBLES);
        end else if (tx_en) begin
            low_run <= '0;
        end else if (low_run < CNT_W'(IFG_NIBBLES)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r2_rise_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> txd == PRE_NIB);

    a_r4_end_after_high_or_sfd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> ($past(state_q) == ST_HIGH || $past(state_q) == ST_SFD));

    a_r5_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd == '0);

    a_r6_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> tx_en);

    a_r7_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    a_r7_underrun_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!tx_en && $past(tx_en)));

    a_r8_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> low_run >= CNT_W'(IFG_NIBBLES));

endmodule

// File: tb/tb_mii_tx_serializer.sv
module tb_mii_tx_serializer;

    localparam int LOG_N = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [3:0] txd;
    logic       tx_en;
    logic       underrun;

    int checks = 0;
    int fails  = 0;

    logic [6:0] log_mem [LOG_N];
    int  wr = 0;
    int  rd = 0;
    logic logging = 1'b0;

    always #2 clk = ~clk;

    mii_tx_serializer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_data   (s_data),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .s_ready  (s_ready),
        .txd      (txd),
        .tx_en    (tx_en),
        .underrun (underrun)
    );

    always @(negedge clk) begin
        if (logging && wr < LOG_N) begin
            log_mem[wr] = {underrun, s_ready, tx_en, txd};
            wr = wr + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int f, input int i);
        return 8'((f * 59 + i * 23 + 17) ^ (i * 7));
    endfunction

    // Drives one frame of L bytes; only U bytes are offered (U == L: complete)
    task automatic drive_frame(input int f, input int L, input int U);
        int  idx = 0;
        logic rdy;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = bval(f, 0);
        s_last  = (L == 1);
        if (U == 0) begin
            @(negedge clk);
            s_valid = 1'b0;
            return;
        end
        forever begin
            rdy = s_ready;
            @(negedge clk);
            if (rdy) begin
                if (s_last) begin
                    s_valid = 1'b0;
                    s_last  = 1'b0;
                    return;
                end
                idx++;
                s_data = bval(f, idx);
                s_last = (idx == L - 1);
                if (idx >= U) begin
                    s_valid = 1'b0;
                    s_last  = 1'b0;
                    return;
                end
            end
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Replays the log for one frame starting at rd
    task automatic analyze(input int f, input int L, input int U, input bit exact_gap);
        int low = 0;
        int bad_low = 0, bad_pre = 0, bad_sfd = 0, bad_data = 0, bad_en = 0, bad_rdy = 0;
        int sent;
        int p;
        logic [7:0] b;
        logic [6:0] e;
        p = rd;
        while (p < wr && log_mem[p][4] == 1'b0) begin
            if (log_mem[p][3:0] != 4'h0) bad_low++;
            if (log_mem[p][5]) bad_rdy++;
            low++;
            p++;
        end
        if (exact_gap)
            check(low == 24, "R8 back-to-back gap length", low, 24);
        else
            check(low >= 24, "R8 minimum gap length", low, 24);
        check(bad_low == 0, "R5 txd zero while tx_en low", bad_low, 0);
        for (int k = 0; k < 15; k++) begin
            e = log_mem[p + k];
            if (e[3:0] != 4'h5 || !e[4]) bad_pre++;
            if (e[5]) bad_rdy++;
        end
        check(bad_pre == 0, "R2 fifteen 0x5 lead-in nibbles with tx_en", bad_pre, 0);
        p += 15;
        e = log_mem[p];
        check(e[3:0] == 4'hD && e[4], "R2 delimiter nibble 0xD", int'(e[3:0]), 13);
        if (!e[5]) bad_rdy++;
        p++;
        sent = (U < L) ? U : L;
        for (int i = 0; i < sent; i++) begin
            b = bval(f, i);
            e = log_mem[p];
            if (e[3:0] != b[3:0]) bad_data++;
            if (!e[4]) bad_en++;
            if (e[5]) bad_rdy++;
            e = log_mem[p + 1];
            if (e[3:0] != b[7:4]) bad_data++;
            if (!e[4]) bad_en++;
            if (e[5] != (i < L - 1)) bad_rdy++;
            p += 2;
        end
        check(bad_data == 0, "R3 low nibble then high nibble per byte", bad_data, 0);
        check(bad_en == 0, "R4 tx_en continuous through frame", bad_en, 0);
        e = log_mem[p];
        check(!e[4], "R4 tx_en low after last nibble", int'(e[4]), 0);
        if (e[5]) bad_rdy++;
        check(bad_rdy == 0, "R6 s_ready only before a low nibble", bad_rdy, 0);
        check(e[6] == (U < L), "R7 underrun flag at frame end", int'(e[6]), int'(U < L));
        check(!log_mem[p + 1][6], "R7 underrun lasts one clock", int'(log_mem[p + 1][6]), 0);
        rd = p;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog R4 run did not finish actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int idle_bad;
        wait_cycles(3);
        check(tx_en == 0 && txd == 0 && s_ready == 0 && underrun == 0,
              "R1 outputs during reset", int'({tx_en, txd, s_ready, underrun}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en == 0 && txd == 0 && s_ready == 0 && underrun == 0,
              "R1 outputs after reset", int'({tx_en, txd, s_ready, underrun}), 0);
        logging = 1'b1;

        idle_bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tx_en || txd != 0) idle_bad++;
        end
        check(idle_bad == 0, "R9 no start while s_valid low", idle_bad, 0);

        // Complete frames of every length 1..20, each from idle
        for (int L = 1; L <= 20; L++) begin
            drive_frame(L, L, L);
            wait_cycles(40);
            analyze(L, L, L, 1'b0);
        end

        // Underrun at every position of a five-byte frame
        for (int U = 0; U < 5; U++) begin
            drive_frame(100 + U, 5, U);
            wait_cycles(40);
            analyze(100 + U, 5, U, 1'b0);
        end

        // Back-to-back frames waiting on the gap
        drive_frame(200, 3, 3);
        drive_frame(201, 1, 1);
        drive_frame(202, 2, 2);
        drive_frame(203, 7, 7);
        drive_frame(204, 4, 2);
        wait_cycles(40);
        analyze(200, 3, 3, 1'b0);
        analyze(201, 1, 1, 1'b1);
        analyze(202, 2, 2, 1'b1);
        analyze(203, 7, 7, 1'b1);
        analyze(204, 4, 2, 1'b1);

        idle_bad = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (tx_en || txd != 0) idle_bad++;
        end
        check(idle_bad == 0, "R9 remains idle after traffic", idle_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule